// File: doc/BRIEF.md
# Corrected-Error Threshold Interrupt Bank

This block models one error-reporting bank that tallies hardware-corrected errors and raises a local interrupt once the tally reaches a limit programmed by software. Software reaches the bank through a small register port that holds two 64-bit registers. The control register contains the limit and an interrupt-enable bit. The status register carries the running error count. Each corrected error arrives as a one-cycle pulse on `err_evt`.

The interrupt request goes to a fixed entry in the local interrupt vector table, at offset 0x2F0 from the controller base. No global or per-bank machine-check enable gates it. Two build-time parameters state whether the threshold field and the interrupt signalling exist. Software can probe for either feature by writing it and reading it back. A capability output is high only when both features exist.

Top module: `cei_bank`

## Requirements
- R1: Bits 14:0 of the control register (`reg_sel`=0) hold the threshold and read back what was written when `HAS_THRESH`=1; when `HAS_THRESH`=0 writes to them are dropped and they read as zero.
- R2: Bit 30 of the control register is the interrupt enable, is 0 after reset, and reads back 0 after a write of 1 when `HAS_SIGNAL`=0.
- R3: All control bits other than 14:0 and 30, and all status bits other than 52:38, read as zero whatever is written.
- R4: The error count is 15 bits wide and sits in status bits 52:38 (`reg_sel`=1). It is 0 after reset, rises by one at each clock edge that samples `err_evt` high, and otherwise holds its value.
- R5: The count saturates at 0x7FFF; further events leave it at 0x7FFF.
- R6: A status write loads the count from write bits 52:38, so writing zero clears it; a status write wins over an event in the same cycle.
- R7: `cei_irq` is high for exactly one cycle, the cycle after the edge whose event makes the count equal a nonzero threshold while bit 30 is set.
- R8: Events after the count has reached the threshold do not fire again until the count is reloaded or the threshold is rewritten so that it can be reached again.
- R9: A zero threshold, or a clear enable bit, never produces an interrupt.
- R10: `cei_lvt_off` is 0x2F0, and `cap_cei` is 1 only when both features are built in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register (combinational) |
| err_evt | input | 1 | One-cycle corrected-error pulse |
| cei_irq | output | 1 | One-cycle interrupt request |
| cei_lvt_off | output | 12 | Vector-table entry offset of the request |
| cap_cei | output | 1 | Capability flag for the threshold interrupt |

## Verification
The bench drives the count right up to the threshold, through it, and on past it. A design that compares with greater-or-equal would fire on every later event, and one that compares before the increment would fire one event late. It clears the count and lowers the threshold to check that the interrupt can fire again. It holds the count at 0x7FFF to catch a counter that wraps to zero and fires a second time. A bare build and full-ones writes check that missing features and reserved bits read zero, where a leaky mask would show stray ones. A status write that lands on the same edge as an event shows whether the write wins.

// File: rtl/cei_bank.sv
module cei_bank #(
  parameter bit HAS_THRESH = 1'b1,
  parameter bit HAS_SIGNAL = 1'b1,
  parameter int CNT_W      = 15,
  parameter int CNT_LSB    = 38,
  parameter int EN_BIT     = 30,
  parameter logic [11:0] LVT_OFF = 12'h2F0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  input  logic        err_evt,
  output logic        cei_irq,
  output logic [11:0] cei_lvt_off,
  output logic        cap_cei
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] thr_q, cnt_q, cnt_inc;
  logic             en_q, ctl_wr, sts_wr, fire;

  assign ctl_wr  = reg_wr && !reg_sel;
  assign sts_wr  = reg_wr && reg_sel;
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  assign fire = err_evt && !sts_wr && en_q && (thr_q != '0)
             && (cnt_q != CNT_MAX) && (cnt_inc == thr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= '0;
      en_q  <= 1'b0;
    end else if (ctl_wr) begin
      thr_q <= HAS_THRESH ? reg_wdata[CNT_W-1:0] : '0;
      en_q  <= HAS_SIGNAL ? reg_wdata[EN_BIT] : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (sts_wr)  cnt_q <= reg_wdata[CNT_LSB +: CNT_W];
    else if (err_evt) cnt_q <= cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cei_irq <= 1'b0;
    else        cei_irq <= fire;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata[CNT_LSB +: CNT_W] = cnt_q;
    end else begin
      reg_rdata[CNT_W-1:0] = thr_q;
      reg_rdata[EN_BIT]    = en_q;
    end
  end

  assign cei_lvt_off = LVT_OFF;
  assign cap_cei     = HAS_THRESH && HAS_SIGNAL;
endmodule

module cei_bank_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic             err_evt,
  input logic             cei_irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] thr_q,
  input logic             en_q
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cei_irq |=> !cei_irq);

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cei_irq |-> $past(err_evt) && $past(en_q) && ($past(thr_q) != '0));

  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && reg_sel) && !err_evt) |=> $stable(cnt_q));

  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && !(reg_wr && reg_sel)) |=> cnt_q == MAXV);

  p_irq_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cei_irq |-> cnt_q == $past(thr_q));
endmodule

bind cei_bank cei_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .err_evt(err_evt), .cei_irq(cei_irq), .cnt_q(cnt_q), .thr_q(thr_q), .en_q(en_q)
);

// File: tb/cei_bank_tb.sv
module cei_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0, err_evt = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] rdata, rdata_b;
  logic        irq, irq_b, cap, cap_b;
  logic [11:0] off, off_b;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cei_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .err_evt(err_evt),
    .cei_irq(irq), .cei_lvt_off(off), .cap_cei(cap));

  cei_bank #(.HAS_THRESH(1'b0), .HAS_SIGNAL(1'b0)) u_bare (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .err_evt(err_evt),
    .cei_irq(irq_b), .cei_lvt_off(off_b), .cap_cei(cap_b));

  // op: 0 event, 1 write threshold with enable, 2 write count
  localparam logic [32:0] VEC [16] = '{
    {2'd1, 15'd3, 15'd0, 1'b0},
    {2'd0, 15'd0, 15'd1, 1'b0},
    {2'd0, 15'd0, 15'd2, 1'b0},
    {2'd0, 15'd0, 15'd3, 1'b1},
    {2'd0, 15'd0, 15'd4, 1'b0},
    {2'd0, 15'd0, 15'd5, 1'b0},
    {2'd2, 15'd0, 15'd0, 1'b0},
    {2'd0, 15'd0, 15'd1, 1'b0},
    {2'd0, 15'd0, 15'd2, 1'b0},
    {2'd0, 15'd0, 15'd3, 1'b1},
    {2'd1, 15'd5, 15'd3, 1'b0},
    {2'd0, 15'd0, 15'd4, 1'b0},
    {2'd0, 15'd0, 15'd5, 1'b1},
    {2'd1, 15'd0, 15'd5, 1'b0},
    {2'd2, 15'd0, 15'd0, 1'b0},
    {2'd0, 15'd0, 15'd1, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic evt, input logic wr, input logic sel, input logic [63:0] d);
    err_evt = evt; reg_wr = wr; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    err_evt = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  function automatic logic [63:0] ctl_word(input logic [14:0] t, input logic en);
    ctl_word = 64'(t) | (64'(en) << 30);
  endfunction

  function automatic logic [63:0] sts_word(input logic [14:0] c);
    sts_word = 64'(c) << 38;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_sel = 1'b0; #1;
    check("R2 reset ctl", rdata, 64'h0);
    check("R7 reset irq", 64'(irq), 64'h0);
    check("R10 lvt off", 64'(off), 64'h2F0);
    check("R10 cap full", 64'(cap), 64'h1);
    check("R10 cap bare", 64'(cap_b), 64'h0);
    reg_sel = 1'b1; #1;
    check("R4 reset count", rdata, 64'h0);

    foreach (VEC[i]) begin
      case (VEC[i][32:31])
        2'd0: step(1'b1, 1'b0, 1'b0, '0);
        2'd1: step(1'b0, 1'b1, 1'b0, ctl_word(VEC[i][30:16], 1'b1));
        default: step(1'b0, 1'b1, 1'b1, sts_word(VEC[i][30:16]));
      endcase
      check("R7/R8/R9 vec irq", 64'(irq), 64'(VEC[i][0]));
      reg_sel = 1'b1; #1;
      check("R4/R6 vec count", rdata, sts_word(VEC[i][15:1]));
    end

    // R3 R1 R2: full-ones control write
    step(1'b0, 1'b1, 1'b0, '1);
    reg_sel = 1'b0; #1;
    check("R3 ctl reserved", rdata, 64'h0000_0000_4000_7FFF);
    check("R1 bare thr drop", rdata_b, 64'h0);
    // R3: full-ones status write
    step(1'b0, 1'b1, 1'b1, '1);
    reg_sel = 1'b1; #1;
    check("R3 sts reserved", rdata, sts_word(15'h7FFF));
    check("R4 bare count", rdata_b, sts_word(15'h7FFF));
    check("R2 bare en", 64'(irq_b), 64'h0);

    // R5: saturation, single fire at the top
    step(1'b0, 1'b1, 1'b1, sts_word(15'h7FFE));
    step(1'b0, 1'b1, 1'b0, ctl_word(15'h7FFF, 1'b1));
    step(1'b1, 1'b0, 1'b0, '0);
    check("R7 fire at max", 64'(irq), 64'h1);
    reg_sel = 1'b1; #1;
    check("R5 reach max", rdata, sts_word(15'h7FFF));
    step(1'b1, 1'b0, 1'b0, '0);
    check("R8 no refire sat", 64'(irq), 64'h0);
    reg_sel = 1'b1; #1;
    check("R5 stays max", rdata, sts_word(15'h7FFF));

    // R9: enable clear, threshold reachable
    step(1'b0, 1'b1, 1'b0, ctl_word(15'd2, 1'b0));
    step(1'b0, 1'b1, 1'b1, sts_word(15'd1));
    step(1'b1, 1'b0, 1'b0, '0);
    check("R9 disabled no irq", 64'(irq), 64'h0);
    reg_sel = 1'b0; #1;
    check("R2 en cleared", rdata, ctl_word(15'd2, 1'b0));

    // R6: write wins over simultaneous event
    step(1'b1, 1'b1, 1'b1, sts_word(15'd10));
    reg_sel = 1'b1; #1;
    check("R6 write wins", rdata, sts_word(15'd10));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule